// File: doc/BRIEF.md
# Configuration Port Command Decoder

This block models the receive side of an on-chip configuration port. Software-like logic elsewhere in the chip feeds 32-bit words to it, one per clock, using an active-low enable and a read/write select. Each byte of an incoming word arrives with its bit order flipped. The decoder restores the order, then ignores everything until it sees the synchronization word. After that it reads single-word register-write packets.

Two target registers matter. The warm-boot start address register captures the location of the image to start next. The command register fires a reboot when it is written with the reprogram code. The reboot shows up as a one-cycle request that carries the captured address. After the request the decoder drops back to the unsynchronized state.

A read cycle returns the stored start address on the output bus. It uses the same per-byte bit order as the input bus, so a word written and then read back compares equal on the wire.

Top module: `cfgport_decoder`

## Requirements
- R1: A word is consumed only on a rising clock edge where `en_n` is 0 and `rd_sel` is 0. A word presented with `en_n` = 1, or with `rd_sel` = 1 (a read), is never decoded.
- R2: Within each byte of `din`, bit i of the byte carries decoded bit 7-i of that byte. Bytes keep their positions: decoded bits [31:24] come from `din[31:24]`, and so on.
- R3: Until the decoded word 0xAA995566 is consumed, every consumed word has no effect. This includes 0xFFFFFFFF, register headers and payloads, and it leaves `hdr_err` unchanged.
- R4: Once synchronized, the decoded word 0x20000000 is a no-operation. It changes neither the stored address nor `hdr_err`.
- R5: Once synchronized, the header 0x30020001 makes the next consumed word the new 32-bit stored start address.
- R6: Once synchronized, the header 0x30008001 followed by the word 0x0000000F raises `boot_req` for exactly one cycle. The pulse starts in the cycle after the edge that consumed 0x0000000F, with `boot_addr` equal to the stored address. Any other command value raises nothing.
- R7: After `boot_req` fires, the decoder is unsynchronized again and needs a new 0xAA995566 before it accepts headers.
- R8: Headers are decoded by field: bits [31:29] = 001 (type 1), bits [28:27] = opcode (00 no-op, 10 write), bits [17:13] = register (16 start address, 4 command), bits [10:0] = word count. Bits [26:18] and [12:11] must be 0. A no-op needs count 0 and register 0. A write needs count 1 and a known register. Any other header while synchronized sets `hdr_err`, which stays set until reset.
- R9: A cycle with `en_n` = 1 cancels a pending payload, so the next consumed word is treated as a header. The synchronized state is kept.
- R10: A read cycle (`en_n` = 0, `rd_sel` = 1) puts the stored address, with bits reversed per byte as in R2, on `dout` one clock later. `dout` holds its value in all other cycles.
- R11: Synchronous active-high `rst` clears the synchronized state, the stored address, `hdr_err`, any pending payload, `boot_req`, `boot_addr` and `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Active-low port enable |
| rd_sel | input | 1 | 1 = read cycle, 0 = write cycle |
| din | input | 32 | Write data, bits reversed within each byte |
| dout | output | 32 | Readback of the stored start address, bits reversed within each byte |
| boot_req | output | 1 | One-cycle warm reboot request |
| boot_addr | output | 32 | Start address that goes with the reboot request |
| hdr_err | output | 1 | Sticky flag for an unrecognised header |

## Verification
The hardest case to reach is a stale payload expectation. A header has been consumed, then the enable drops for a cycle, and then a word arrives that would have been taken as payload. From the ports this is visible only through the readback and through a later reboot.

The bench builds this case in a fixed order. It consumes a start-address header, idles one cycle, and then sends a no-op word that would have overwritten the address. It reads the address back to confirm it did not change. It then fires a reboot without a new sync word, which shows that synchronization survived the idle cycle. Address patterns for several boot images are swept through the full command sequence, and expected words are computed in the bench by reversing bits within each byte.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
   typedef enum logic [1:0] {
      PEND_NONE = 2'd0,
      PEND_ADDR = 2'd1,
      PEND_CMD  = 2'd2
   } pend_e;

   typedef struct packed {
      logic is_noop;
      logic wr_addr;
      logic wr_cmd;
   } hdr_t;
endpackage

// File: rtl/cfgport_bitswap.sv
module cfgport_bitswap #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic [DATA_W-1:0] a,
   output logic [DATA_W-1:0] y
);
   localparam int NBYTES = DATA_W / BYTE_W;

   generate
      if (DATA_W % BYTE_W != 0) begin : g_bad_width
         $error("cfgport_bitswap: DATA_W must be a multiple of BYTE_W");
      end
      for (genvar b = 0; b < NBYTES; b++) begin : g_byte
         for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
            assign y[b*BYTE_W + i] = a[b*BYTE_W + (BYTE_W-1-i)];
         end
      end
   endgenerate
endmodule

// File: rtl/cfgport_hdr_decode.sv
module cfgport_hdr_decode
   import cfgport_pkg::*;
#(
   parameter int          DATA_W   = 32,
   parameter logic [4:0]  ADDR_REG = 5'd16,
   parameter logic [4:0]  CMD_REG  = 5'd4
) (
   input  logic [DATA_W-1:0] w,
   output hdr_t              hdr
);
   localparam logic [2:0] TYPE1   = 3'b001;
   localparam logic [1:0] OP_NOOP = 2'b00;
   localparam logic [1:0] OP_WR   = 2'b10;

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("cfgport_hdr_decode: header layout needs DATA_W == 32");
      end
   endgenerate

   logic [2:0]  f_type;
   logic [1:0]  f_op;
   logic [4:0]  f_reg;
   logic [10:0] f_cnt;
   logic        rsv_zero;
   logic        is_write;

   always_comb begin
      f_type   = w[31:29];
      f_op     = w[28:27];
      f_reg    = w[17:13];
      f_cnt    = w[10:0];
      rsv_zero = (w[26:18] == '0) && (w[12:11] == '0);
      is_write = (f_type == TYPE1) && (f_op == OP_WR) && (f_cnt == 11'd1) && rsv_zero;
      hdr.is_noop = (f_type == TYPE1) && (f_op == OP_NOOP) && (f_cnt == '0)
                    && (f_reg == '0) && rsv_zero;
      hdr.wr_addr = is_write && (f_reg == ADDR_REG);
      hdr.wr_cmd  = is_write && (f_reg == CMD_REG);
   end
endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
   import cfgport_pkg::*;
#(
   parameter int                 DATA_W    = 32,
   parameter logic [DATA_W-1:0]  SYNC_WORD = 32'hAA995566,
   parameter logic [DATA_W-1:0]  REPROG    = 32'h0000000F
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en_n,
   input  logic              rd_sel,
   input  logic [DATA_W-1:0] w,
   input  hdr_t              hdr,
   output logic [DATA_W-1:0] addr_q,
   output logic              boot_req,
   output logic [DATA_W-1:0] boot_addr,
   output logic              hdr_err
);
   logic  synced;
   pend_e pend;
   logic  take;

   assign take = !en_n && !rd_sel;

   always_ff @(posedge clk) begin
      if (rst) begin
         synced    <= 1'b0;
         pend      <= PEND_NONE;
         addr_q    <= '0;
         hdr_err   <= 1'b0;
         boot_req  <= 1'b0;
         boot_addr <= '0;
      end else begin
         boot_req <= 1'b0;
         if (en_n) begin
            pend <= PEND_NONE;
         end else if (take) begin
            if (!synced) begin
               if (w == SYNC_WORD) synced <= 1'b1;
            end else begin
               case (pend)
                  PEND_ADDR: begin
                     addr_q <= w;
                     pend   <= PEND_NONE;
                  end
                  PEND_CMD: begin
                     pend <= PEND_NONE;
                     if (w == REPROG) begin
                        boot_req  <= 1'b1;
                        boot_addr <= addr_q;
                        synced    <= 1'b0;
                     end
                  end
                  default: begin
                     if (hdr.wr_addr)      pend    <= PEND_ADDR;
                     else if (hdr.wr_cmd)  pend    <= PEND_CMD;
                     else if (!hdr.is_noop) hdr_err <= 1'b1;
                  end
               endcase
            end
         end
      end
   end

   AST_BOOT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      boot_req |=> !boot_req); // R6
   AST_BOOT_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
      boot_req |-> $past(take)); // R1
   AST_DESYNC_ON_BOOT: assert property (@(posedge clk) disable iff (rst)
      boot_req |-> !synced); // R7
   AST_IDLE_CANCELS: assert property (@(posedge clk) disable iff (rst)
      en_n |=> (pend == PEND_NONE)); // R9
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
      hdr_err |=> hdr_err); // R8
   AST_PRESYNC_NO_PEND: assert property (@(posedge clk) disable iff (rst)
      !synced |-> (pend == PEND_NONE)); // R3
endmodule

// File: rtl/cfgport_decoder.sv
module cfgport_decoder
   import cfgport_pkg::*;
#(
   parameter int                 DATA_W    = 32,
   parameter int                 BYTE_W    = 8,
   parameter logic [DATA_W-1:0]  SYNC_WORD = 32'hAA995566,
   parameter logic [DATA_W-1:0]  REPROG    = 32'h0000000F,
   parameter logic [4:0]         ADDR_REG  = 5'd16,
   parameter logic [4:0]         CMD_REG   = 5'd4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en_n,
   input  logic              rd_sel,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              boot_req,
   output logic [DATA_W-1:0] boot_addr,
   output logic              hdr_err
);
   logic [DATA_W-1:0] w_dec;
   logic [DATA_W-1:0] addr_q;
   logic [DATA_W-1:0] addr_sw;
   hdr_t              hdr;
   logic              rd_cycle;

   cfgport_bitswap #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_swap_in (
      .a(din), .y(w_dec));

   cfgport_bitswap #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_swap_out (
      .a(addr_q), .y(addr_sw));

   cfgport_hdr_decode #(.DATA_W(DATA_W), .ADDR_REG(ADDR_REG), .CMD_REG(CMD_REG)) u_hdr (
      .w(w_dec), .hdr(hdr));

   cfgport_ctrl #(.DATA_W(DATA_W), .SYNC_WORD(SYNC_WORD), .REPROG(REPROG)) u_ctrl (
      .clk(clk), .rst(rst), .en_n(en_n), .rd_sel(rd_sel), .w(w_dec), .hdr(hdr),
      .addr_q(addr_q), .boot_req(boot_req), .boot_addr(boot_addr), .hdr_err(hdr_err));

   assign rd_cycle = !en_n && rd_sel;

   always_ff @(posedge clk) begin
      if (rst)           dout <= '0;
      else if (rd_cycle) dout <= addr_sw;
   end

   AST_DOUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !rd_cycle |=> $stable(dout)); // R10
endmodule

// File: tb/cfgport_decoder_test.sv
module cfgport_decoder_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en_n = 1'b1;
   logic        rd_sel = 1'b1;
   logic [31:0] din = '0;
   logic [31:0] dout, boot_addr;
   logic        boot_req, hdr_err;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   localparam logic [31:0] W_DUMMY = 32'hFFFFFFFF;
   localparam logic [31:0] W_SYNC  = 32'hAA995566;
   localparam logic [31:0] W_NOOP  = 32'h20000000;
   localparam logic [31:0] W_HADDR = 32'h30020001;
   localparam logic [31:0] W_HCMD  = 32'h30008001;
   localparam logic [31:0] W_PROG  = 32'h0000000F;

   always #5 clk = ~clk;

   cfgport_decoder uut (.clk(clk), .rst(rst), .en_n(en_n), .rd_sel(rd_sel), .din(din),
      .dout(dout), .boot_req(boot_req), .boot_addr(boot_addr), .hdr_err(hdr_err));

   function automatic logic [31:0] swp(input logic [31:0] v);
      logic [31:0] r;
      for (int b = 0; b < 4; b++)
         for (int i = 0; i < 8; i++)
            r[b*8+i] = v[b*8+7-i];
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // send a decoded word; returns at the next negedge, outputs settled
   task automatic wr(input logic [31:0] v);
      en_n = 1'b0; rd_sel = 1'b0; din = swp(v);
      @(negedge clk);
      en_n = 1'b1; rd_sel = 1'b1;
   endtask

   task automatic idle();
      en_n = 1'b1; rd_sel = 1'b0; din = '0;
      @(negedge clk);
   endtask

   task automatic rd(output logic [31:0] v);
      en_n = 1'b0; rd_sel = 1'b1; din = W_SYNC;
      @(negedge clk);
      en_n = 1'b1;
      v = dout;
   endtask

   task automatic do_reset();
      rst = 1'b1; en_n = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] r, a, prev;
      @(negedge clk);
      do_reset();
      chk("R11 boot_req", {31'd0, boot_req}, 0);
      chk("R11 hdr_err", {31'd0, hdr_err}, 0);
      chk("R11 dout", dout, 0);
      chk("R11 boot_addr", boot_addr, 0);

      // R3: full sequence without sync does nothing
      wr(W_DUMMY); wr(W_HADDR); wr(32'h12345678); wr(W_HCMD); wr(W_PROG);
      chk("R3 no boot before sync", {31'd0, boot_req}, 0);
      wr(32'h50000000);
      chk("R3 no error before sync", {31'd0, hdr_err}, 0);
      rd(r); chk("R3 address untouched", r, 0);

      // R1: sync word with enable high or as a read is not consumed
      en_n = 1'b1; rd_sel = 1'b0; din = swp(W_SYNC); @(negedge clk);
      en_n = 1'b0; rd_sel = 1'b1; din = swp(W_SYNC); @(negedge clk);
      en_n = 1'b1;
      wr(W_HADDR); wr(32'h0BADF00D); wr(W_HCMD); wr(W_PROG);
      chk("R1 no boot without consumed sync", {31'd0, boot_req}, 0);
      rd(r); chk("R1 address untouched", r, 0);

      // R2 R5 R6 R10: sweep boot images
      for (int k = 0; k < 8; k++) begin
         a = (k * 32'h00200000) ^ (32'h01020304 << k);
         wr(W_DUMMY); wr(W_SYNC); wr(W_NOOP); wr(W_HADDR); wr(a);
         wr(W_HCMD);
         chk("R6 no early boot", {31'd0, boot_req}, 0);
         wr(W_PROG);
         chk("R6 boot pulse", {31'd0, boot_req}, 1);
         chk("R6 R5 R2 boot address", boot_addr, a);
         wr(W_NOOP);
         chk("R6 pulse one cycle", {31'd0, boot_req}, 0);
         idle();
         rd(r); chk("R10 R2 readback", r, swp(a));
         chk("R4 no error on no-op", {31'd0, hdr_err}, 0);
      end

      // R7: after boot, headers need a new sync
      prev = a;
      wr(W_HADDR); wr(32'hDEAD0001);
      rd(r); chk("R7 unsynced after boot", r, swp(prev));

      // R4: no-ops change nothing
      wr(W_SYNC); wr(W_NOOP); wr(W_NOOP);
      rd(r); chk("R4 address kept", r, swp(prev));
      chk("R4 no error", {31'd0, hdr_err}, 0);

      // R6: other command value does not boot, still synced
      wr(W_HCMD); wr(32'h00000007);
      chk("R6 no boot on other cmd", {31'd0, boot_req}, 0);
      wr(W_HADDR); wr(32'hCAFE0000);
      rd(r); chk("R6 still synced after other cmd", r, swp(32'hCAFE0000));

      // R9: idle cycle cancels pending payload, keeps sync
      wr(W_HADDR); idle(); wr(W_NOOP);
      rd(r); chk("R9 payload cancelled", r, swp(32'hCAFE0000));
      chk("R9 no error from no-op", {31'd0, hdr_err}, 0);
      wr(W_HCMD); wr(W_PROG);
      chk("R9 sync kept, boot fires", {31'd0, boot_req}, 1);
      chk("R9 boot address", boot_addr, 32'hCAFE0000);

      // R1: read between header and payload does not consume
      wr(W_SYNC); wr(W_HADDR);
      rd(r);
      wr(32'h00C0FFEE);
      rd(r); chk("R1 read not consumed as payload", r, swp(32'h00C0FFEE));

      // R8: bad count sets error, sticky
      wr(32'h30020002);
      chk("R8 bad count error", {31'd0, hdr_err}, 1);
      wr(W_NOOP); idle();
      chk("R8 error sticky", {31'd0, hdr_err}, 1);

      // R8: other bad headers, each after reset
      do_reset();
      wr(W_SYNC); wr(32'h50000000);
      chk("R8 type 2 error", {31'd0, hdr_err}, 1);
      do_reset();
      wr(W_SYNC); wr(32'h3000C001);
      chk("R8 unknown register error", {31'd0, hdr_err}, 1);
      do_reset();
      wr(W_SYNC); wr(32'h20000001);
      chk("R8 no-op with count error", {31'd0, hdr_err}, 1);
      do_reset();
      wr(W_SYNC); wr(W_SYNC);
      chk("R8 sync while synced error", {31'd0, hdr_err}, 1);

      // R11: reset clears everything including sync
      do_reset();
      chk("R11 err cleared", {31'd0, hdr_err}, 0);
      wr(W_HADDR); wr(32'h11111111);
      rd(r); chk("R11 sync and address cleared", r, 0);
      chk("R11 boot_addr cleared", boot_addr, 0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule